// File: doc/BRIEF.md
# Integer loop delay search

This block estimates the whole-sample lag between the baseband stream sent to a power amplifier and the stream that comes back through the receive path. Each stream is reduced to one bit per sample. The bit is set when the sample's magnitude, approximated as |I| + |Q|, is strictly larger than the previous sample's magnitude. The bit comes from a comparator and needs no multiplier. The returned stream may be scaled, rotated or bent by a monotonic amplitude curve, and its rising and falling pattern still matches the transmitted stream once the two are aligned.

After a start pulse the block tries candidate lags 0 to 7 in turn. For each candidate it delays the transmit bit sequence by that many samples and compares it with the feedback bit sequence. Each agreement is an XNOR of the two bits. The agreements are counted over a fixed window of samples. A candidate is accepted when its count exceeds a threshold and also exceeds the count of the next candidate. The accepted lag is then held on the output with a lock flag until the next start. If a full pass finds no peak, the search wraps back to lag 0 by itself and continues.

Top module: `intdelay_search`

## Requirements
- R1: After reset, `locked` is 0 and `delay` is 0.
- R2: Sample magnitude is |I| + |Q|. A stream's direction bit is 1 when the current magnitude is strictly greater than the previous one. As a result, feedback that is the transmit stream scaled by 2 and rotated by 90 degrees (I' = -2Q, Q' = 2I) locks to the same lag as the unmodified stream would.
- R3: For the current candidate lag, one agreement is the XNOR of the transmit direction bit delayed by that lag and the current feedback direction bit. Agreements are counted over WIN = 64 consecutive samples, and one window is spent per candidate.
- R4: Candidates are tried in increasing order from 0, starting with the cycle after start. A lag D below 7 is accepted at the end of the window for D+1, which is (D+2)*64 cycles after start. Lag 7 is accepted at the end of its own window, 512 cycles after start. No lock can appear earlier than 2*WIN cycles after start.
- R5: Candidate d (0 to 6) is accepted when its count exceeds 48 (3/4 of WIN) and exceeds the count of candidate d+1. Candidate 7 is accepted when its count exceeds 48. On acceptance, `delay` shows d and `locked` rises.
- R6: When candidate 7 finishes without acceptance, the search continues from candidate 0 without a new start. It locks once correlated feedback appears.
- R7: While `locked` is 1 and `start` is low, both `locked` and `delay` stay constant, whatever the feedback does.
- R8: A start pulse clears `locked` and sets `delay` to 0 in the next cycle. It then begins a new search from candidate 0, and this also applies when the block is already locked.
- R9: Feedback that is statistically independent of the transmit stream never produces a lock.
- R10: `delay` reads 0 whenever `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a new search |
| tx_i | input | SW | Transmit in-phase sample, signed |
| tx_q | input | SW | Transmit quadrature sample, signed |
| fb_i | input | SW | Feedback in-phase sample, signed |
| fb_q | input | SW | Feedback quadrature sample, signed |
| delay | output | DW | Accepted whole-sample lag |
| locked | output | 1 | High once a lag has been accepted |

## Verification
The hardest state to reach from the ports is the wrap from candidate 7 back to candidate 0. It only happens when no candidate in a full pass clears the threshold. The bench first drives feedback from an independent random source long enough for several complete passes to fail. It then switches the feedback to a lagged, rotated and scaled copy of the transmit stream without issuing a new start. A later lock at the right lag can only come from the search having wrapped. The exact lock cycle for each lag is compared against the window count, which confirms the candidate order and the look-ahead peak rule.

// File: rtl/intdelay_search.sv
module intdelay_search #(
  parameter int SW     = 12,
  parameter int WIN    = 64,
  parameter int DW     = 3,
  parameter int TH_NUM = 3,
  parameter int TH_DEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [SW-1:0] tx_i,
  input  logic signed [SW-1:0] tx_q,
  input  logic signed [SW-1:0] fb_i,
  input  logic signed [SW-1:0] fb_q,
  output logic [DW-1:0]        delay,
  output logic                 locked
);
  localparam int NCAND = 1 << DW;
  localparam int AW    = SW + 1;
  localparam int WCW   = $clog2(WIN);
  localparam int CW    = $clog2(WIN + 1);
  localparam int TH    = WIN * TH_NUM / TH_DEN;

  function automatic logic [AW-1:0] mag(input logic signed [SW-1:0] i, input logic signed [SW-1:0] q);
    logic [SW-1:0] ai, aq;
    ai = i[SW-1] ? $unsigned(-i) : $unsigned(i);
    aq = q[SW-1] ? $unsigned(-q) : $unsigned(q);
    return AW'(ai) + AW'(aq);
  endfunction

  logic [AW-1:0]    tx_mag, fb_mag, tx_prev, fb_prev;
  logic             tx_up, fb_up;
  logic [NCAND-2:0] tx_hist;
  logic [NCAND-1:0] taps;
  logic             agree;

  assign tx_mag = mag(tx_i, tx_q);
  assign fb_mag = mag(fb_i, fb_q);
  assign taps   = {tx_hist, tx_up};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev <= '0;
      fb_prev <= '0;
      tx_up   <= 1'b0;
      fb_up   <= 1'b0;
      tx_hist <= '0;
    end else begin
      tx_prev <= tx_mag;
      fb_prev <= fb_mag;
      tx_up   <= tx_mag > tx_prev;
      fb_up   <= fb_mag > fb_prev;
      tx_hist <= {tx_hist[NCAND-3:0], tx_up};
    end
  end

  logic            searching;
  logic [DW-1:0]   cand;
  logic [WCW-1:0]  wpos;
  logic [CW-1:0]   acc, prev;
  logic [CW-1:0]   total;
  logic            last, prev_peak, top_peak;

  assign agree     = ~(taps[cand] ^ fb_up);
  assign total     = acc + CW'(agree);
  assign last      = wpos == WCW'(WIN - 1);
  assign prev_peak = (cand != '0) && (prev > CW'(TH)) && (prev > total);
  assign top_peak  = (cand == DW'(NCAND - 1)) && (total > CW'(TH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      searching <= 1'b0;
      locked    <= 1'b0;
      delay     <= '0;
      cand      <= '0;
      wpos      <= '0;
      acc       <= '0;
      prev      <= '0;
    end else if (start) begin
      searching <= 1'b1;
      locked    <= 1'b0;
      delay     <= '0;
      cand      <= '0;
      wpos      <= '0;
      acc       <= '0;
    end else if (searching) begin
      if (!last) begin
        wpos <= wpos + WCW'(1);
        acc  <= total;
      end else begin
        wpos <= '0;
        acc  <= '0;
        if (prev_peak) begin
          searching <= 1'b0;
          locked    <= 1'b1;
          delay     <= cand - DW'(1);
        end else if (top_peak) begin
          searching <= 1'b0;
          locked    <= 1'b1;
          delay     <= cand;
        end else begin
          cand <= cand + DW'(1);
          prev <= total;
        end
      end
    end
  end
endmodule

// File: rtl/intdelay_search_chk.sv
module intdelay_search_chk #(
  parameter int WIN = 64,
  parameter int DW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] delay,
  input logic          locked
);
  localparam int LIM = 2 * WIN;
  localparam int SCW = $clog2(LIM + 1);

  logic [SCW-1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)                since <= '0;
    else if (start)            since <= '0;
    else if (since != SCW'(LIM)) since <= since + SCW'(1);
  end

  // R7
  hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !start) |=> (locked && $stable(delay)));

  // R7
  drop_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(start));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!locked && delay == '0));

  // R10
  idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> delay == '0);

  // R4
  early_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> since >= SCW'(LIM));
endmodule

bind intdelay_search intdelay_search_chk #(.WIN(WIN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .delay(delay), .locked(locked)
);

// File: tb/intdelay_search_test.sv
`timescale 1ns/1ps
module intdelay_search_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [11:0] tx_i = '0, tx_q = '0, fb_i = '0, fb_q = '0;
  logic [2:0] delay;
  logic locked;

  intdelay_search uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tx_i(tx_i), .tx_q(tx_q), .fb_i(fb_i), .fb_q(fb_q),
    .delay(delay), .locked(locked)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] seed_a = 32'h1234_5678;
  logic [31:0] seed_b = 32'h9abc_def1;
  int fb_lag = 0;
  bit fb_rand = 0;
  logic signed [11:0] hi [0:7];
  logic signed [11:0] hq [0:7];

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v = s;
    v = v ^ (v << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  initial for (int k = 0; k < 8; k++) begin hi[k] = '0; hq[k] = '0; end

  always @(negedge clk) begin
    seed_a = xs(seed_a);
    seed_b = xs(seed_b);
    for (int k = 7; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
    hi[0] = 12'($signed(seed_a[9:0]));
    hq[0] = 12'($signed(seed_a[25:16]));
    tx_i = hi[0];
    tx_q = hq[0];
    if (fb_rand) begin
      fb_i = 12'($signed(seed_b[9:0]));
      fb_q = 12'($signed(seed_b[25:16]));
    end else begin
      fb_i = -(hq[fb_lag] <<< 1);
      fb_q = hi[fb_lag] <<< 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(locked == 1'b0, "R8 lock cleared after start", int'(locked), 0);
    check(delay == 3'd0, "R10 delay zero while searching", int'(delay), 0);
  endtask

  task automatic wait_lock(input int limit, output int n);
    n = 1;
    while (!locked && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check(locked == 1'b0, "R1 reset locked", int'(locked), 0);
    check(delay == 3'd0, "R1 reset delay", int'(delay), 0);
  endtask

  task automatic t_lock(input int lag);
    int n;
    int exp_t;
    fb_rand = 0;
    fb_lag = lag;
    repeat (10) @(negedge clk);
    pulse_start();
    wait_lock(1200, n);
    exp_t = (lag == 7) ? 512 : (lag + 2) * 64;
    check(locked == 1'b1, "R5/R2 lock on rotated scaled feedback", int'(locked), 1);
    check(int'(delay) == lag, "R5 accepted lag", int'(delay), lag);
    check(n >= exp_t - 1 && n <= exp_t + 1, "R4/R3 lock cycle from window order", n, exp_t);
    repeat (200) @(negedge clk);
    check(locked == 1'b1 && int'(delay) == lag, "R7 lock held", int'(delay), lag);
  endtask

  task automatic t_wrap();
    int n;
    bit seen = 0;
    fb_rand = 1;
    pulse_start();
    for (int k = 0; k < 3 * 512; k++) begin
      @(negedge clk);
      if (locked) seen = 1;
    end
    check(!seen, "R9 no lock on independent feedback", int'(seen), 0);
    fb_rand = 0;
    fb_lag = 2;
    wait_lock(2 * 512 + 300, n);
    check(locked == 1'b1, "R6 lock after wrap without start", int'(locked), 1);
    check(delay == 3'd2, "R6 lag after wrap", int'(delay), 2);
  endtask

  task automatic t_restart();
    int n;
    fb_rand = 0;
    fb_lag = 3;
    repeat (10) @(negedge clk);
    pulse_start();
    wait_lock(1200, n);
    check(delay == 3'd3, "R5 first lag before restart", int'(delay), 3);
    fb_lag = 5;
    repeat (400) @(negedge clk);
    check(locked == 1'b1 && delay == 3'd3, "R7 feedback change ignored while locked", int'(delay), 3);
    pulse_start();
    wait_lock(1200, n);
    check(locked == 1'b1 && delay == 3'd5, "R8 restart finds new lag", int'(delay), 5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    t_reset();
    t_lock(0);
    t_lock(3);
    t_lock(6);
    t_lock(7);
    t_wrap();
    t_restart();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule